// File: doc/BRIEF.md
# Tri-State Aware Watchdog Timer

This block watches a processor heartbeat line that may be driven low, driven high, or left floating. The floating detection happens outside the block. The line's state arrives here already decoded into a two-bit code. Each change between the two driven levels restarts an internal count that advances on strobes of a shared prescaled timebase. If the count reaches its limit before the next change, the active-low watchdog output falls. It stays low until the heartbeat moves again.

Two conditions hold the count at zero and stop it from advancing: the reset status from the reset generator, and a floating heartbeat. With the heartbeat floating, the watchdog function is switched off. The output then only follows the supply-good input, so it acts as a low-supply indicator. Whenever the supply-good input drops, the output goes low at once, whatever the count holds.

Top module: `hb_watchdog`

## Requirements
- R1: After the asynchronous block reset `rst_ni` is released, `wdog_n_o` is high and the count starts from zero.
- R2: The heartbeat code on `hb_state_i` is 2'b00 for driven low, 2'b01 for driven high, and 2'b10 or 2'b11 for floating. While the heartbeat is driven and no change of driven level is seen for `TIMEOUT_TICKS` timebase strobes, `wdog_n_o` goes low. It does not go low before `TIMEOUT_TICKS - 2` strobes have passed since the count restarted, and it is low no later than `TIMEOUT_TICKS + 3` clock cycles after the heartbeat was last changed.
- R3: Once `wdog_n_o` is low from a timeout, it stays low while the heartbeat stays at one driven level. A change between driven low and driven high releases it within three clock cycles and restarts the count.
- R4: While `sys_rst_i` is high, the count is held at zero and no timeout occurs. Counting starts from zero once `sys_rst_i` falls and the heartbeat is driven.
- R5: While the heartbeat code is floating, the count is held at zero and no timeout occurs. Entering or leaving the floating state is not a toggle. After a return to a driven level, counting starts from zero and a timeout follows if there is no further change.
- R6: When `supply_ok_i` is low, `wdog_n_o` is low on the next clock edge, whatever the count holds, including while the heartbeat floats.
- R7: The count advances only on clock cycles where `tick_i` is high. When `tick_i` stays low, no timeout occurs, however long the heartbeat sits still. The count never passes `TIMEOUT_TICKS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | One-cycle strobe of the prescaled timebase |
| sys_rst_i | input | 1 | Reset-asserted status from the reset generator, active high |
| supply_ok_i | input | 1 | Supply above reset threshold, active high |
| hb_state_i | input | 2 | Decoded heartbeat state (00 low, 01 high, 1x floating) |
| wdog_n_o | output | 1 | Watchdog output, active low |

## Verification
The heartbeat is driven in several patterns. Regular toggles tell a live processor apart from a stuck one. A held level shows both the timeout and that it stays asserted. A toggle after expiry shows the release. A detour through the floating state shows that the float code clears the count and that the return to a driven level restarts it. Holding the reset status and holding the timebase strobe low each have to suppress a timeout that would otherwise come. Dropping supply-good, both with the heartbeat driven and with it floating, separates the low-supply path from the timer path.

// File: rtl/hb_watchdog_pkg.sv
package hb_watchdog_pkg;

    typedef enum logic [1:0] {
        HB_LOW   = 2'b00,
        HB_HIGH  = 2'b01,
        HB_FLOAT = 2'b10
    } hb_code_e;

    typedef struct packed {
        logic [1:0] cur;
        logic [1:0] prv;
    } hb_samp_t;

endpackage

// File: rtl/hb_edge_sampler.sv
module hb_edge_sampler
    import hb_watchdog_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] hb_state_i,
    output logic       floating_o,
    output logic       toggle_o
);

    hb_samp_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cur = hb_state_i;
        s_d.prv = s_q.cur;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{cur: HB_FLOAT, prv: HB_FLOAT};
        end else begin
            s_q <= s_d;
        end
    end

    // bit 1 set means floating; bit 0 is the driven level
    assign floating_o = s_q.cur[1];
    assign toggle_o   = !s_q.cur[1] && !s_q.prv[1] && (s_q.cur[0] != s_q.prv[0]);

endmodule

// File: rtl/hb_timeout_counter.sv
module hb_timeout_counter #(
    parameter int TIMEOUT_TICKS = 1600
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic clear_i,
    output logic expired_o
);

    localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clear_i) begin
            c_d.cnt = '0;
        end else if (tick_i && (c_q.cnt != LIMIT)) begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign expired_o = (c_q.cnt == LIMIT);

    // R7: count stays within the limit
    a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c_q.cnt <= LIMIT);

    // R7: without a strobe or clear the count holds
    a_r7_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !clear_i) |=> $stable(c_q.cnt));

    // R4 / R5: a clear request empties the count
    a_r4_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (c_q.cnt == '0));

endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog
    import hb_watchdog_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1600
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       sys_rst_i,
    input  logic       supply_ok_i,
    input  logic [1:0] hb_state_i,
    output logic       wdog_n_o
);

    typedef struct packed {
        logic wdog_n;
    } out_st_t;

    logic    floating;
    logic    toggle;
    logic    expired;
    logic    clear;
    out_st_t o_d, o_q;

    hb_edge_sampler u_sampler (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .hb_state_i (hb_state_i),
        .floating_o (floating),
        .toggle_o   (toggle)
    );

    assign clear = sys_rst_i || floating || toggle;

    hb_timeout_counter #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_counter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .clear_i   (clear),
        .expired_o (expired)
    );

    always_comb begin
        o_d        = o_q;
        o_d.wdog_n = supply_ok_i && !expired;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            o_q <= '{wdog_n: 1'b1};
        end else begin
            o_q <= o_d;
        end
    end

    assign wdog_n_o = o_q.wdog_n;

    // R6: low supply forces the output low on the next edge
    a_r6_low_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_ok_i |=> !wdog_n_o);

    // R4: reset status keeps the timer from asserting the output
    a_r4_no_timeout_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sys_rst_i && supply_ok_i && !expired) |=> wdog_n_o);

    // R5: floating heartbeat leaves only the supply path
    a_r5_float_supply_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (floating && supply_ok_i && !expired) |=> wdog_n_o);

endmodule

// File: tb/hb_watchdog_tb_top.sv
module hb_watchdog_tb_top;

    localparam int T = 8;

    logic       clk_i = 1'b0;
    logic       rst_ni;
    logic       tick_i;
    logic       sys_rst_i;
    logic       supply_ok_i;
    logic [1:0] hb_state_i;
    logic       wdog_n_o;

    int checks = 0;
    int errors = 0;

    always #4 clk_i = ~clk_i;

    hb_watchdog #(.TIMEOUT_TICKS(T)) dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .sys_rst_i   (sys_rst_i),
        .supply_ok_i (supply_ok_i),
        .hb_state_i  (hb_state_i),
        .wdog_n_o    (wdog_n_o)
    );

    task automatic check(input string req, input logic exp);
        checks++;
        if (wdog_n_o !== exp) begin
            errors++;
            $display("FAIL %s: wdog_n_o=%b expected %b", req, wdog_n_o, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic flip_hb();
        hb_state_i = (hb_state_i == 2'b00) ? 2'b01 : 2'b00;
    endtask

    // heartbeat just restarted: high through T-2, low by T+3
    task automatic expect_timeout(input string req);
        cyc(T - 2);
        check(req, 1'b1);
        cyc(5);
        check(req, 1'b0);
    endtask

    task automatic t_reset_state();
        check("R1", 1'b1);
        sys_rst_i = 1'b0;
        expect_timeout("R1");
    endtask

    task automatic t_sticky_and_release();
        cyc(3 * T);
        check("R3", 1'b0);
        flip_hb();
        cyc(3);
        check("R3", 1'b1);
        expect_timeout("R2");
    endtask

    task automatic t_live_heartbeat();
        flip_hb();
        for (int i = 0; i < 6; i++) begin
            cyc(T - 2);
            flip_hb();
        end
        cyc(3);
        check("R2", 1'b1);
        expect_timeout("R2");
    endtask

    task automatic t_sys_reset();
        sys_rst_i = 1'b1;
        cyc(3);
        check("R4", 1'b1);
        cyc(3 * T);
        check("R4", 1'b1);
        sys_rst_i = 1'b0;
        expect_timeout("R4");
    endtask

    task automatic t_floating();
        hb_state_i = 2'b10;
        cyc(3);
        check("R5", 1'b1);
        cyc(3 * T);
        check("R5", 1'b1);
        hb_state_i = 2'b11;
        cyc(2 * T);
        check("R5", 1'b1);
        supply_ok_i = 1'b0;
        cyc(1);
        check("R6", 1'b0);
        supply_ok_i = 1'b1;
        cyc(1);
        check("R6", 1'b1);
        hb_state_i = 2'b01;
        expect_timeout("R5");
    endtask

    task automatic t_supply_driven();
        flip_hb();
        cyc(2);
        supply_ok_i = 1'b0;
        cyc(1);
        check("R6", 1'b0);
        supply_ok_i = 1'b1;
        cyc(1);
        check("R6", 1'b1);
    endtask

    task automatic t_tick_gate();
        tick_i = 1'b0;
        flip_hb();
        cyc(4 * T);
        check("R7", 1'b1);
        tick_i = 1'b1;
        cyc(T + 4);
        check("R7", 1'b0);
        cyc(4 * T);
        check("R7", 1'b0);
    endtask

    initial begin
        rst_ni      = 1'b0;
        tick_i      = 1'b1;
        sys_rst_i   = 1'b1;
        supply_ok_i = 1'b1;
        hb_state_i  = 2'b01;
        cyc(3);
        rst_ni = 1'b1;
        t_reset_state();
        t_sticky_and_release();
        t_live_heartbeat();
        t_sys_reset();
        t_floating();
        t_supply_driven();
        t_tick_gate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule